// File: doc/BRIEF.md
# Dual-Target Wiper Register File

This block is the register back end of a digitally set potentiometer. A byte-wide write/read bus, standing in for the back end of a two-wire serial slave, reaches three locations: a wiper location, a step-setup location and a mode location. The wiper location is backed by two physical registers. One is a volatile wiper position. The other is an initial-value copy that models the nonvolatile setting. The wiper loads from the initial-value copy when the block leaves reset.

A mode bit decides where a write to the wiper location goes. It can update both registers, or only the volatile wiper. A read of the wiper location always returns the volatile wiper. Every write to a mapped location produces a one-cycle change pulse. The stepping logic uses this pulse to restart its holdoff. The step-setup fields are exported to that logic without any change.

Top module: `wiper_regfile`

## Requirements
- R1: While `rst_n` is low, the wiper loads from the initial-value register, the step and mode registers clear to 00h, and `change_pulse_o` is 0. While `por_n` is also low, both the wiper and the initial-value register take `IV_DEFAULT` (40h).
- R2: When the mode bit is 0, a write to address 00h updates both the wiper and the initial-value register on the next clock edge.
- R3: When the mode bit is 1, a write to address 00h updates only the wiper, and the initial-value register keeps its value.
- R4: A read of address 00h returns `{1'b0, wiper}` in either mode.
- R5: Address 01h holds the step setup. Bits 4:0 are the step count (`step_count_o`) and bits 6:5 are the period select (`step_period_o`). Bit 7 reads back as 0.
- R6: Address 02h holds the mode register. Bit 7 is the mode bit (`wr_only_o`) and bits 6:0 read back as 0.
- R7: Reads of any address other than 00h, 01h and 02h return 00h. Writes to such an address change no register and raise no pulse.
- R8: `change_pulse_o` is high for exactly the one cycle after each write to 00h, 01h or 02h. It stays high through back-to-back writes.
- R9: Bit 7 of a write to 00h is ignored. The wiper and initial-value registers are 7 bits wide.
- R10: The initial-value register keeps its contents through `rst_n` alone. Only `por_n` or a write changes it.
- R11: Writing the mode register leaves the wiper and the initial-value register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the volatile state |
| por_n | input | 1 | Synchronous active-low power-on load of the initial value |
| bus_we | input | 1 | Write strobe, one write per cycle when high |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| wiper_o | output | 7 | Volatile wiper position |
| init_val_o | output | 7 | Initial-value (nonvolatile model) register |
| step_count_o | output | 5 | Step count field |
| step_period_o | output | 2 | Step period select field |
| wr_only_o | output | 1 | Mode bit: 1 means writes to 00h touch only the wiper |
| change_pulse_o | output | 1 | One-cycle pulse after each mapped write |

## Verification
Two things can happen in the same cycle. One is the change pulse from a write to the mode register. The other is the next write, to address 00h, which must already be steered by the new mode. The bench provokes this with a mode write immediately followed by a wiper write. It judges the result in three ways: the pulse must stay high for two cycles in a row, the wiper must take the new data, and the initial-value register must stay as it was. The reverse order is also run, with mode 0 restored right before a wiper write, and both registers must then update.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int WIPER_W = 7;
  localparam int STEP_W  = 5;
  localparam int PER_W   = 2;

  localparam logic [ADDR_W-1:0] ADDR_WIPER = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_STEP  = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h02;

  localparam int PER_LSB  = STEP_W;
  localparam int MODE_BIT = DATA_W - 1;

  typedef struct packed {
    logic wiper;
    logic step;
    logic ctrl;
  } wsel_t;

  function automatic logic [DATA_W-1:0] pack_wiper(input logic [WIPER_W-1:0] w);
    return {{(DATA_W-WIPER_W){1'b0}}, w};
  endfunction

  function automatic logic [DATA_W-1:0] pack_step(input logic [STEP_W-1:0] c,
                                                  input logic [PER_W-1:0] p);
    return {{(DATA_W-STEP_W-PER_W){1'b0}}, p, c};
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic mode);
    return {mode, {(DATA_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/wrf_decode.sv
module wrf_decode
  import wrf_pkg::*;
(
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_only,
  output wsel_t             sel,
  output logic              wiper_we,
  output logic              iv_we,
  output logic              mapped_wr
);
  always_comb begin
    sel.wiper = bus_we && (bus_addr == ADDR_WIPER);
    sel.step  = bus_we && (bus_addr == ADDR_STEP);
    sel.ctrl  = bus_we && (bus_addr == ADDR_CTRL);
  end

  // the wiper location steers to one or two physical registers
  assign wiper_we  = sel.wiper;
  assign iv_we     = sel.wiper && !wr_only;
  assign mapped_wr = sel.wiper || sel.step || sel.ctrl;
endmodule

// File: rtl/wrf_regs.sv
module wrf_regs
  import wrf_pkg::*;
#(
  parameter logic [WIPER_W-1:0] IV_DEFAULT = 7'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_n,
  input  logic [DATA_W-1:0]  wdata,
  input  wsel_t              sel,
  input  logic               wiper_we,
  input  logic               iv_we,
  output logic [WIPER_W-1:0] wiper,
  output logic [WIPER_W-1:0] iv,
  output logic [STEP_W-1:0]  step_cnt,
  output logic [PER_W-1:0]   step_per,
  output logic               wr_only
);
  // initial-value copy: only power-on or a steered write touch it
  always_ff @(posedge clk) begin
    if (!por_n)     iv <= IV_DEFAULT;
    else if (iv_we) iv <= wdata[WIPER_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!por_n)         wiper <= IV_DEFAULT;
    else if (!rst_n)    wiper <= iv;
    else if (wiper_we)  wiper <= wdata[WIPER_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !por_n) begin
      step_cnt <= '0;
      step_per <= '0;
      wr_only  <= 1'b0;
    end else begin
      if (sel.step) begin
        step_cnt <= wdata[STEP_W-1:0];
        step_per <= wdata[PER_LSB +: PER_W];
      end
      if (sel.ctrl) wr_only <= wdata[MODE_BIT];
    end
  end

  assert_dual_write_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (wiper_we && !wr_only) |=> (iv == $past(wdata[WIPER_W-1:0])) &&
                               (wiper == $past(wdata[WIPER_W-1:0])));

  assert_wiper_only_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (wiper_we && wr_only) |=> $stable(iv) && (wiper == $past(wdata[WIPER_W-1:0])));

  assert_ctrl_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    sel.ctrl |=> $stable(wiper) && $stable(iv));

  assert_iv_kept_R10: assert property (@(posedge clk) disable iff (!por_n)
    !iv_we |=> $stable(iv));
endmodule

// File: rtl/wrf_readmux.sv
module wrf_readmux
  import wrf_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WIPER_W-1:0] wiper,
  input  logic [STEP_W-1:0]  step_cnt,
  input  logic [PER_W-1:0]   step_per,
  input  logic               wr_only,
  output logic [DATA_W-1:0]  rdata
);
  always_comb begin
    unique case (addr)
      ADDR_WIPER: rdata = pack_wiper(wiper);
      ADDR_STEP:  rdata = pack_step(step_cnt, step_per);
      ADDR_CTRL:  rdata = pack_ctrl(wr_only);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/wiper_regfile.sv
module wiper_regfile
  import wrf_pkg::*;
#(
  parameter logic [6:0] IV_DEFAULT = 7'h40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [6:0] wiper_o,
  output logic [6:0] init_val_o,
  output logic [4:0] step_count_o,
  output logic [1:0] step_period_o,
  output logic       wr_only_o,
  output logic       change_pulse_o
);
  wsel_t sel;
  logic  wiper_we, iv_we, mapped_wr;

  wrf_decode u_dec (
    .bus_we(bus_we), .bus_addr(bus_addr), .wr_only(wr_only_o),
    .sel(sel), .wiper_we(wiper_we), .iv_we(iv_we), .mapped_wr(mapped_wr)
  );

  wrf_regs #(.IV_DEFAULT(IV_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wdata(bus_wdata), .sel(sel),
    .wiper_we(wiper_we), .iv_we(iv_we), .wiper(wiper_o), .iv(init_val_o),
    .step_cnt(step_count_o), .step_per(step_period_o), .wr_only(wr_only_o)
  );

  wrf_readmux u_rd (
    .addr(bus_addr), .wiper(wiper_o), .step_cnt(step_count_o),
    .step_per(step_period_o), .wr_only(wr_only_o), .rdata(bus_rdata)
  );

  // change strobe toward the stepping holdoff
  always_ff @(posedge clk) begin
    if (!rst_n || !por_n) change_pulse_o <= 1'b0;
    else                  change_pulse_o <= mapped_wr;
  end

  assert_pulse_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    mapped_wr |=> change_pulse_o);

  assert_pulse_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !mapped_wr |=> !change_pulse_o);

  assert_unmapped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_we && !mapped_wr) |=> $stable(wiper_o) && $stable(init_val_o) &&
                               $stable(step_count_o) && $stable(wr_only_o));
endmodule

// File: tb/tb_wiper_regfile.sv
module tb_wiper_regfile;
  logic       clk = 0;
  logic       rst_n = 0, por_n = 0, bus_we = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [6:0] wiper_o, init_val_o;
  logic [4:0] step_count_o;
  logic [1:0] step_period_o;
  logic       wr_only_o, change_pulse_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wiper_regfile dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 wiper at por", wiper_o, 7'h40);
    chk("R1 iv at por", init_val_o, 7'h40);
    chk("R1 step clear", {step_period_o, step_count_o}, 0);
    chk("R1 mode clear", wr_only_o, 0);
    chk("R1 no pulse", change_pulse_o, 0);
    rd(8'h00, d); chk("R4 read 00 after reset", d, 8'h40);
  endtask

  task automatic t_dual;
    wr(8'h00, 8'h15);
    chk("R8 pulse after write", change_pulse_o, 1);
    chk("R2 wiper", wiper_o, 7'h15);
    chk("R2 iv", init_val_o, 7'h15);
    @(negedge clk); chk("R8 pulse one cycle", change_pulse_o, 0);
  endtask

  task automatic t_wiper_only;
    logic [7:0] d;
    wr(8'h02, 8'h80);
    chk("R6 mode bit", wr_only_o, 1);
    chk("R11 wiper kept", wiper_o, 7'h15);
    chk("R11 iv kept", init_val_o, 7'h15);
    rd(8'h02, d); chk("R6 reserved read zero", d, 8'h80);
    wr(8'h00, 8'h33);
    chk("R3 wiper", wiper_o, 7'h33);
    chk("R3 iv kept", init_val_o, 7'h15);
    rd(8'h00, d); chk("R4 read 00 in mode 1", d, 8'h33);
    wr(8'h02, 8'h7F);
    chk("R6 low bits no mode", wr_only_o, 0);
    rd(8'h02, d); chk("R6 reserved bits zero", d, 8'h00);
    chk("R11 wiper kept on mode clear", wiper_o, 7'h33);
  endtask

  task automatic t_step;
    logic [7:0] d;
    wr(8'h01, 8'hFF);
    chk("R5 count", step_count_o, 5'h1F);
    chk("R5 period", step_period_o, 2'h3);
    rd(8'h01, d); chk("R5 bit7 reads zero", d, 8'h7F);
    wr(8'h01, 8'h45);
    chk("R5 count 2", step_count_o, 5'h05);
    chk("R5 period 2", step_period_o, 2'h2);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(8'h03, 8'hFF);
    chk("R7 no pulse", change_pulse_o, 0);
    chk("R7 wiper kept", wiper_o, 7'h33);
    chk("R7 step kept", step_count_o, 5'h05);
    chk("R7 mode kept", wr_only_o, 0);
    rd(8'h03, d); chk("R7 read unmapped", d, 8'h00);
    rd(8'hFF, d); chk("R7 read FF", d, 8'h00);
  endtask

  task automatic t_bit7;
    logic [7:0] d;
    wr(8'h00, 8'hAA);
    chk("R9 wiper", wiper_o, 7'h2A);
    chk("R9 iv", init_val_o, 7'h2A);
    rd(8'h00, d); chk("R9 read", d, 8'h2A);
  endtask

  task automatic t_back_to_back;
    @(negedge clk); bus_we = 1; bus_addr = 8'h02; bus_wdata = 8'h80;
    @(negedge clk); bus_addr = 8'h00; bus_wdata = 8'h11;
    chk("R8 pulse first", change_pulse_o, 1);
    @(negedge clk); bus_we = 0;
    chk("R8 pulse held", change_pulse_o, 1);
    chk("R3 new mode steers", init_val_o, 7'h2A);
    chk("R3 wiper b2b", wiper_o, 7'h11);
    @(negedge clk); bus_we = 1; bus_addr = 8'h02; bus_wdata = 8'h00;
    @(negedge clk); bus_addr = 8'h00; bus_wdata = 8'h22;
    @(negedge clk); bus_we = 0;
    chk("R2 after mode cleared", init_val_o, 7'h22);
    chk("R2 wiper b2b", wiper_o, 7'h22);
  endtask

  task automatic t_rst_keeps_iv;
    wr(8'h02, 8'h80);
    wr(8'h00, 8'h05);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R10 iv kept", init_val_o, 7'h22);
    chk("R1 wiper from iv", wiper_o, 7'h22);
    chk("R1 mode cleared", wr_only_o, 0);
    chk("R1 step cleared", step_count_o, 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dual();
    t_wiper_only();
    t_step();
    t_unmapped();
    t_bit7();
    t_back_to_back();
    t_rst_keeps_iv();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule